// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the control sequencer that starts an 8-bit processor and moves it into an interrupt handler. It holds the program counter, the stack pointer and the status byte. It collects interrupt requests of three kinds: a non-maskable request, a one-shot maskable request, and a set of level-type maskable sources. Each level source can be raised and lowered on its own. When the execution unit signals an instruction boundary, the block decides whether to enter a handler. If it does, it drives a byte-wide memory port to save the return state on the stack and then to fetch the handler address.

Entry takes a fixed seven cycles. During those cycles `busy_o` is high and the block ignores the execution unit's register loads. On the last cycle, `done_o` reports the kind of entry and the cycles it used. After a synchronous reset, the block runs only the vector-fetch part of the sequence. This loads the program counter from the reset vector. A sticky halt (jam) input stops all later handler entries until the next reset.

The maskable path does not use the live interrupt-disable flag. It uses a copy of that flag captured at the previous boundary, so a flag change made by the instruction now finishing has no effect until one boundary later.

Top module: `irq_entry_seq`

## Requirements
- R1: A boundary strobe (`boundary_i`) sampled while `busy_o` is low either starts an entry or leaves the block idle. An entry keeps `busy_o` high for exactly 7 cycles. `done_o` is high in the 7th of those cycles, with `cycles_o` = 7. With no request pending, `busy_o` stays low.
- R2: An entry writes three bytes on three consecutive cycles: the PC high byte, then the PC low byte, then the status byte. The status byte is written with bit 4 forced to 0 and bit 5 forced to 1.
- R3: Each stack write goes to address 0x0100 + S, and S decreases by one after each write. A completed entry leaves `sp_o` three lower than before.
- R4: Handler addresses are read low byte first, then high byte. NMI reads 0xFFFA/0xFFFB, maskable entry reads 0xFFFE/0xFFFF, and reset reads 0xFFFC/0xFFFD. The PC ends as {high, low}. `kind_o` encodes 1 = NMI, 2 = maskable, 3 = reset, and 0 when `done_o` is low.
- R5: When both kinds are pending, NMI wins. A maskable entry sets status bit 2 (interrupt disable); an NMI entry leaves bit 2 unchanged. Both clear status bit 4.
- R6: Maskable entry is blocked when status bit 2, as captured at the previous boundary, is 1. The live value of bit 2 at the current boundary does not decide.
- R7: After `jam_i` has been high for one cycle, no entry of any kind starts until the next reset.
- R8: Reset sets S to SP_INIT (0xFD by default), sets the status to 0x04, clears the jam state and all requests, and loads the PC from the reset vector. It finishes with `done_o` high, `kind_o` = 3 and `cycles_o` = 0.
- R9: Each level source bit is set by its `lvl_set_i` bit and cleared by its `lvl_clr_i` bit, independently of the other bits. A taken entry does not clear the level bits, so an unmasked level source is taken again at a later boundary.
- R10: At every boundary sampled while idle, the pending NMI and one-shot maskable requests are discarded, whether or not an entry starts. A one-shot request that is masked or suppressed by jam is lost.
- R11: `pc_ld_i` and `p_ld_i` have no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the reset vector fetch |
| boundary_i | input | 1 | Instruction boundary strobe from the execution unit |
| lvl_set_i | input | SRC_W | Per-source set of the level request bits |
| lvl_clr_i | input | SRC_W | Per-source clear of the level request bits |
| nmi_pulse_i | input | 1 | Posts a one-shot non-maskable request |
| tmp_pulse_i | input | 1 | Posts a one-shot maskable request |
| jam_i | input | 1 | Enters the sticky halted state |
| pc_ld_i | input | 1 | Loads the PC from `pc_din_i` when idle |
| pc_din_i | input | 16 | PC value from the execution unit |
| p_ld_i | input | 1 | Loads the status from `p_din_i` when idle |
| p_din_i | input | 8 | Status value from the execution unit |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe (stack push) |
| mem_re_o | output | 1 | Memory read strobe (vector fetch) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_re_o` |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | High while an entry or reset sequence runs |
| done_o | output | 1 | Last cycle of a sequence |
| kind_o | output | 2 | Kind of the finished sequence |
| cycles_o | output | CYC_W | Cycles used by the finished sequence |

## Verification
The properties assume that the memory returns read data exactly one cycle after `mem_re_o`. They also assume that `rst` is held for at least one clock, and that a second reset arrives only while the block is idle. The sequence-length and status-byte checks assume that no reset cuts a sequence short. The stimulus therefore raises `boundary_i` only when `busy_o` is low and issues resets only between sequences. Its memory model answers every read with a one-cycle registered response. Register loads are driven into a running sequence only on purpose, to show that they are ignored.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int FL_I      = 2;
  localparam int FL_B      = 4;
  localparam int FL_U      = 5;
  localparam int ENTRY_CYC = 7;

  localparam logic [7:0]        STACK_PAGE = 8'h01;
  localparam logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_P,
    ST_VEC_LO, ST_VEC_HI, ST_VEC_WAIT, ST_FINISH
  } seq_state_t;

  typedef enum logic [1:0] {K_NONE, K_NMI, K_IRQ, K_RESET} entry_kind_t;
endpackage

// File: rtl/irq_entry_req.sv
module irq_entry_req import irq_entry_pkg::*; #(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] lvl_set_i,
  input  logic [SRC_W-1:0] lvl_clr_i,
  input  logic             nmi_pulse_i,
  input  logic             tmp_pulse_i,
  input  logic             decide_i,
  input  logic             mask_i,
  input  logic             jam_i,
  output logic             take_nmi_o,
  output logic             take_irq_o
);
  logic [SRC_W-1:0] lvl_q;
  logic             nmi_q, tmp_q, irq_pend;

  // level sources: set has priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
    end else begin
      for (int i = 0; i < SRC_W; i++) begin
        if (lvl_set_i[i])      lvl_q[i] <= 1'b1;
        else if (lvl_clr_i[i]) lvl_q[i] <= 1'b0;
      end
    end
  end

  // one-shot requests are dropped at every idle boundary; a new pulse survives
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b0;
      tmp_q <= 1'b0;
    end else begin
      nmi_q <= nmi_pulse_i | (nmi_q & ~decide_i);
      tmp_q <= tmp_pulse_i | (tmp_q & ~decide_i);
    end
  end

  assign irq_pend   = tmp_q | (|lvl_q);
  assign take_nmi_o = decide_i & nmi_q & ~jam_i;
  assign take_irq_o = decide_i & ~nmi_q & irq_pend & ~mask_i & ~jam_i;
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm import irq_entry_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  output seq_state_t state_o
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:     if (start_i) st_d = ST_PUSH_HI;
      ST_PUSH_HI:  st_d = ST_PUSH_LO;
      ST_PUSH_LO:  st_d = ST_PUSH_P;
      ST_PUSH_P:   st_d = ST_VEC_LO;
      ST_VEC_LO:   st_d = ST_VEC_HI;
      ST_VEC_HI:   st_d = ST_VEC_WAIT;
      ST_VEC_WAIT: st_d = ST_FINISH;
      ST_FINISH:   st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  // reset enters the fetch half of the sequence directly
  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_VEC_LO;
    else     st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq import irq_entry_pkg::*; #(
  parameter int         SRC_W   = 4,
  parameter logic [7:0] SP_INIT = 8'hFD,
  parameter int         CYC_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic [SRC_W-1:0]  lvl_set_i,
  input  logic [SRC_W-1:0]  lvl_clr_i,
  input  logic              nmi_pulse_i,
  input  logic              tmp_pulse_i,
  input  logic              jam_i,
  input  logic              pc_ld_i,
  input  logic [15:0]       pc_din_i,
  input  logic              p_ld_i,
  input  logic [7:0]        p_din_i,
  output logic [15:0]       mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [15:0]       pc_o,
  output logic [7:0]        sp_o,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        kind_o,
  output logic [CYC_W-1:0]  cycles_o
);
  localparam logic [DATA_W-1:0] I_BIT      = DATA_W'(1) << FL_I;
  localparam logic [DATA_W-1:0] B_BIT      = DATA_W'(1) << FL_B;
  localparam logic [DATA_W-1:0] U_BIT      = DATA_W'(1) << FL_U;
  localparam logic [CYC_W-1:0]  ENTRY_COST = CYC_W'(ENTRY_CYC);

  seq_state_t        state;
  entry_kind_t       kind_q;
  logic [ADDR_W-1:0] pc_q, vec_q;
  logic [DATA_W-1:0] sp_q, p_q, push_status;
  logic              pi_q, jam_q;
  logic              decide, take_nmi, take_irq;

  assign decide = boundary_i & (state == ST_IDLE);

  irq_entry_req #(.SRC_W(SRC_W)) u_req (
    .clk(clk), .rst(rst), .lvl_set_i(lvl_set_i), .lvl_clr_i(lvl_clr_i),
    .nmi_pulse_i(nmi_pulse_i), .tmp_pulse_i(tmp_pulse_i), .decide_i(decide),
    .mask_i(pi_q), .jam_i(jam_q), .take_nmi_o(take_nmi), .take_irq_o(take_irq)
  );

  irq_entry_fsm u_fsm (
    .clk(clk), .rst(rst), .start_i(take_nmi | take_irq), .state_o(state)
  );

  assign push_status = (p_q & ~B_BIT) | U_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      sp_q   <= SP_INIT;
      p_q    <= I_BIT;
      pi_q   <= 1'b1;
      jam_q  <= 1'b0;
      kind_q <= K_RESET;
      vec_q  <= VEC_RST;
    end else begin
      if (jam_i) jam_q <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (pc_ld_i) pc_q <= pc_din_i;
          if (p_ld_i)  p_q  <= p_din_i;
          if (take_nmi) begin
            kind_q <= K_NMI;
            vec_q  <= VEC_NMI;
          end else if (take_irq) begin
            kind_q <= K_IRQ;
            vec_q  <= VEC_IRQ;
          end else if (decide) begin
            pi_q <= p_q[FL_I];
          end
        end
        ST_PUSH_HI, ST_PUSH_LO: sp_q <= sp_q - 8'd1;
        ST_PUSH_P: begin
          sp_q <= sp_q - 8'd1;
          p_q  <= (kind_q == K_IRQ) ? ((p_q & ~B_BIT) | I_BIT) : (p_q & ~B_BIT);
        end
        ST_VEC_HI:   pc_q[7:0]  <= mem_rdata_i;
        ST_VEC_WAIT: pc_q[15:8] <= mem_rdata_i;
        ST_FINISH:   pi_q       <= p_q[FL_I];
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    case (state)
      ST_PUSH_HI: begin mem_we_o = 1'b1; mem_addr_o = {STACK_PAGE, sp_q}; mem_wdata_o = pc_q[15:8]; end
      ST_PUSH_LO: begin mem_we_o = 1'b1; mem_addr_o = {STACK_PAGE, sp_q}; mem_wdata_o = pc_q[7:0];  end
      ST_PUSH_P:  begin mem_we_o = 1'b1; mem_addr_o = {STACK_PAGE, sp_q}; mem_wdata_o = push_status; end
      ST_VEC_LO:  begin mem_re_o = 1'b1; mem_addr_o = vec_q; end
      ST_VEC_HI:  begin mem_re_o = 1'b1; mem_addr_o = {vec_q[ADDR_W-1:1], 1'b1}; end
      default: ;
    endcase
  end

  assign pc_o     = pc_q;
  assign sp_o     = sp_q;
  assign status_o = p_q;
  assign busy_o   = (state != ST_IDLE);
  assign done_o   = (state == ST_FINISH);
  assign kind_o   = done_o ? kind_q : K_NONE;
  assign cycles_o = (done_o && kind_q != K_RESET) ? ENTRY_COST : '0;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk import irq_entry_pkg::*; #(
  parameter int CYC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             jam_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       kind_o,
  input logic [CYC_W-1:0] cycles_o,
  input logic [7:0]       status_o,
  input logic [7:0]       sp_o,
  input logic             mem_we_o,
  input logic             mem_re_o,
  input logic [15:0]      mem_addr_o,
  input logic [7:0]       mem_wdata_o
);
  logic [3:0] run_q;
  logic       jam_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      jam_seen <= 1'b0;
    end else begin
      run_q <= busy_o ? run_q + 4'd1 : 4'd0;
      if (jam_i) jam_seen <= 1'b1;
    end
  end

  a_r1_seq_len: assert property (@(posedge clk) disable iff (rst)
    (done_o && kind_o != K_RESET) |-> (run_q == 4'(ENTRY_CYC - 1) && cycles_o == CYC_W'(ENTRY_CYC)));
  a_r1_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (!mem_re_o && busy_o));
  a_r2_status_byte: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o) && $past(mem_we_o, 2)) |-> (mem_wdata_o[FL_U] && !mem_wdata_o[FL_B]));
  a_r3_stack_page: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_addr_o == {STACK_PAGE, sp_o}));
  a_r3_sp_step: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> (sp_o == $past(sp_o) - 8'd1));
  a_r4_vector_window: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |-> (mem_addr_o >= VEC_NMI));
  a_r5_irq_sets_i: assert property (@(posedge clk) disable iff (rst)
    (done_o && kind_o == K_IRQ) |-> (status_o[FL_I] && !status_o[FL_B]));
  a_r7_jam_hold: assert property (@(posedge clk) disable iff (rst)
    (jam_seen && !busy_o) |=> !busy_o);
  a_r8_reset_status: assert property (@(posedge clk) disable iff (rst)
    (done_o && kind_o == K_RESET) |-> (status_o == 8'h04 && cycles_o == '0));
endmodule

bind irq_entry_seq irq_entry_chk #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .jam_i(jam_i), .busy_o(busy_o), .done_o(done_o),
  .kind_o(kind_o), .cycles_o(cycles_o), .status_o(status_o), .sp_o(sp_o),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  localparam int SRC_W = 4;
  localparam int CYC_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary_i = 0, nmi_pulse_i = 0, tmp_pulse_i = 0, jam_i = 0;
  logic [SRC_W-1:0] lvl_set_i = '0, lvl_clr_i = '0;
  logic pc_ld_i = 0, p_ld_i = 0;
  logic [15:0] pc_din_i = '0;
  logic [7:0]  p_din_i = '0;
  logic [15:0] mem_addr_o, pc_o;
  logic mem_we_o, mem_re_o, busy_o, done_o;
  logic [7:0] mem_wdata_o, sp_o, status_o;
  logic [7:0] mem_rdata_i = '0;
  logic [1:0] kind_o;
  logic [CYC_W-1:0] cycles_o;

  always #10 clk = ~clk;

  irq_entry_seq #(.SRC_W(SRC_W), .CYC_W(CYC_W)) dut_i (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .lvl_set_i(lvl_set_i),
    .lvl_clr_i(lvl_clr_i), .nmi_pulse_i(nmi_pulse_i), .tmp_pulse_i(tmp_pulse_i),
    .jam_i(jam_i), .pc_ld_i(pc_ld_i), .pc_din_i(pc_din_i), .p_ld_i(p_ld_i),
    .p_din_i(p_din_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .pc_o(pc_o), .sp_o(sp_o), .status_o(status_o), .busy_o(busy_o),
    .done_o(done_o), .kind_o(kind_o), .cycles_o(cycles_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] vecmem [6];            // bytes at 0xFFFA..0xFFFF
  logic [15:0] mpc;
  logic [7:0]  msp, mp;

  typedef struct { logic [15:0] a; logic [7:0] d; string tag; } wr_t;
  wr_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // synchronous memory: vector bytes answered one cycle after the read strobe
  always @(posedge clk) begin
    if (mem_re_o) begin
      if (mem_addr_o >= 16'hFFFA) mem_rdata_i <= vecmem[int'(mem_addr_o) - 'hFFFA];
      else                        mem_rdata_i <= 8'hEE;
    end
  end

  // scoreboard monitor for stack writes
  always @(negedge clk) begin
    if (!rst && mem_we_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected stack write", {mem_addr_o, 8'h00, mem_wdata_o}, 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk(mem_addr_o == e.a, {e.tag, " R3 push address"}, mem_addr_o, e.a);
        chk(mem_wdata_o == e.d, {e.tag, " R2 push data"}, mem_wdata_o, e.d);
      end
    end
  end

  task automatic set_pc(input logic [15:0] v);
    pc_ld_i = 1; pc_din_i = v; @(negedge clk); pc_ld_i = 0; mpc = v;
  endtask
  task automatic set_p(input logic [7:0] v);
    p_ld_i = 1; p_din_i = v; @(negedge clk); p_ld_i = 0; mp = v;
  endtask
  task automatic pulse_nmi(); nmi_pulse_i = 1; @(negedge clk); nmi_pulse_i = 0; endtask
  task automatic pulse_tmp(); tmp_pulse_i = 1; @(negedge clk); tmp_pulse_i = 0; endtask
  task automatic lvl_set(input logic [SRC_W-1:0] m); lvl_set_i = m; @(negedge clk); lvl_set_i = '0; endtask
  task automatic lvl_clr(input logic [SRC_W-1:0] m); lvl_clr_i = m; @(negedge clk); lvl_clr_i = '0; endtask

  task automatic no_entry(input string tag);
    boundary_i = 1; @(negedge clk); boundary_i = 0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy_o, {tag, " no entry"}, busy_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic run_entry(input logic [1:0] k, input bit poke, input string tag);
    int n;
    logic [15:0] vpc;
    vpc = (k == 2'd1) ? {vecmem[1], vecmem[0]} : {vecmem[5], vecmem[4]};
    exp_q.push_back('{{8'h01, msp}, mpc[15:8], tag}); msp--;
    exp_q.push_back('{{8'h01, msp}, mpc[7:0], tag});  msp--;
    exp_q.push_back('{{8'h01, msp}, (mp & 8'hEF) | 8'h20, tag}); msp--;
    mp = mp & 8'hEF;
    if (k == 2'd2) mp = mp | 8'h04;
    mpc = vpc;
    boundary_i = 1; @(negedge clk); boundary_i = 0;
    n = 0;
    if (poke) begin pc_ld_i = 1; pc_din_i = 16'hDEAD; p_ld_i = 1; p_din_i = 8'hFF; end
    while (!done_o && n < 20) begin
      if (busy_o) n++;
      @(negedge clk);
    end
    pc_ld_i = 0; p_ld_i = 0;
    chk(n + 1 == 7, {tag, " R1 busy length"}, n + 1, 7);
    chk(cycles_o == 4'd7, {tag, " R1 cycles"}, cycles_o, 7);
    chk(kind_o == k, {tag, " R4 kind"}, kind_o, k);
    chk(pc_o == mpc, {tag, poke ? " R11 pc" : " R4 vector pc"}, pc_o, mpc);
    chk(status_o == mp, {tag, poke ? " R11 status" : " R5 status"}, status_o, mp);
    chk(sp_o == msp, {tag, " R3 sp"}, sp_o, msp);
    @(negedge clk);
    chk(!busy_o, {tag, " R1 idle after"}, busy_o, 0);
    chk(exp_q.size() == 0, {tag, " R2 all pushes seen"}, exp_q.size(), 0);
  endtask

  task automatic do_reset(input logic [7:0] lo, input logic [7:0] hi);
    int n;
    vecmem[2] = lo; vecmem[3] = hi;
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    n = 0;
    while (!done_o && n < 20) begin n++; @(negedge clk); end
    chk(kind_o == 2'd3, "R8 reset kind", kind_o, 3);
    chk(cycles_o == 0, "R8 reset cycles", cycles_o, 0);
    chk(pc_o == {hi, lo}, "R8 reset pc", pc_o, {hi, lo});
    chk(status_o == 8'h04, "R8 reset status", status_o, 8'h04);
    chk(sp_o == 8'hFD, "R8 reset sp", sp_o, 8'hFD);
    @(negedge clk);
    mpc = {hi, lo}; msp = 8'hFD; mp = 8'h04;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vecmem[0] = 8'h10; vecmem[1] = 8'h80; vecmem[4] = 8'h20; vecmem[5] = 8'h90;
    @(negedge clk);
    do_reset(8'h34, 8'h12);                       // R8
    no_entry("R1 nothing pending");
    // NMI taken while latched mask is set; B cleared in pushed and live status
    set_pc(16'hABCD); set_p(8'hD1); pulse_nmi();
    run_entry(2'd1, 0, "R5 nmi");
    // level source taken with latched mask clear
    lvl_set(4'b0100);
    run_entry(2'd2, 0, "R9 level irq");
    // live I clear but latched I set: blocked, then taken at next boundary
    set_p(8'hC1);
    no_entry("R6 latched mask blocks");
    run_entry(2'd2, 0, "R9 level persists");
    // independent level bits
    lvl_clr(4'b0100); lvl_set(4'b0011); lvl_clr(4'b0001);
    set_p(8'h00);
    no_entry("R6 mask from previous boundary");
    run_entry(2'd2, 0, "R9 bit1 remains");
    lvl_clr(4'b0010); set_p(8'h00);
    no_entry("R9 masked");
    no_entry("R9 all bits cleared");
    // live I set but latched I clear: taken
    set_p(8'h04); lvl_set(4'b1000);
    run_entry(2'd2, 0, "R6 live flag ignored");
    lvl_clr(4'b1000);
    // priority
    set_p(8'h00);
    no_entry("R5 setup");
    lvl_set(4'b0001); pulse_nmi();
    run_entry(2'd1, 0, "R5 nmi wins");
    run_entry(2'd2, 0, "R5 irq follows");
    lvl_clr(4'b0001);
    // one-shot maskable dropped when masked
    pulse_tmp();
    no_entry("R10 masked one-shot");
    set_p(8'h00);
    no_entry("R10 setup");
    no_entry("R10 one-shot dropped");
    pulse_tmp();
    run_entry(2'd2, 0, "R10 one-shot taken");
    set_p(8'h00);
    no_entry("R10 setup2");
    no_entry("R10 one-shot cleared after entry");
    // loads ignored while busy
    set_pc(16'h1357); pulse_nmi();
    run_entry(2'd1, 1, "R11 loads ignored");
    // jam suppresses everything
    jam_i = 1; @(negedge clk); jam_i = 0;
    pulse_nmi();
    no_entry("R7 jam blocks nmi");
    lvl_set(4'b0001); set_p(8'h00);
    no_entry("R7 jam setup");
    no_entry("R7 jam blocks irq");
    // reset clears jam and requests
    do_reset(8'h78, 8'h56);
    no_entry("R8 requests cleared by reset");
    pulse_nmi();
    run_entry(2'd1, 0, "R8 jam cleared");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule